// File: doc/BRIEF.md
# Ethernet Receive Frame Formatter

This block sits between a receive MAC and a paged packet memory. An incoming frame arrives one byte per cycle, with a start marker on the first byte and an end marker on the last. On the start byte the block checks its configuration inputs and the page allocator. If the frame is taken, it claims one page and streams the payload into page memory through a byte write port. When the frame ends, the block adds any zero padding, the CRC and the trailing word, and then writes the header. Finally it pushes the page number into the receive queue and pulses a receive event.

A record consists of a two-byte status word and a two-byte byte count, both little-endian. The payload follows, padded to the minimum frame size when the frame is short. The CRC-32 comes next unless stripping is requested, and a trailing word closes the record. For a frame of odd length, the CRC sits on the 16-bit boundary after the even part of the payload. The final odd byte then moves into the trailing word, together with a marker in its control byte. A frame whose record would not fit in one page is dropped, and its page is handed back through a release port.

Top module: `rx_frame_formatter`

## Requirements
- R1: A frame whose start byte arrives while `cfg_rx_en` is 0 or `cfg_soft_rst` is 1 is refused: no page is taken, nothing is written and nothing is queued.
- R2: A frame whose start byte arrives while `alloc_avail` is 0 is refused in the same way.
- R3: If the record size (R5) exceeds PAGE_BYTES, the frame is not queued. The page taken for it is returned through a one-cycle `rel_valid` pulse that carries that page on `rel_page`.
- R4: For a frame of L < MIN_FRAME (64) bytes, the payload area holds the L bytes at offsets 4 onward, followed by zero bytes up to offset 4+MIN_FRAME-1. Such a frame is never treated as odd.
- R5: Offsets 0-1 hold the status word and offsets 2-3 the byte count, each least significant byte first. The count is 6 + E + C, where C is 4 when the CRC is kept and 0 when it is stripped. E is MIN_FRAME for short frames and otherwise L rounded down to even.
- R6: Status bit 12 (0x1000) is set for a frame with L >= MIN_FRAME and L odd. Bit 11 (0x0800) is set when L > LONG_LIMIT. All other status bits are 0.
- R7: Unless `cfg_strip_crc` is 1, four CRC bytes follow the E payload bytes, least significant byte first. The CRC is the reflected CRC-32 (polynomial 0xEDB88320 in shifted-right form), starting from all ones and inverted at the end, taken over the L received bytes only.
- R8: The last two bytes of the record are the final payload byte followed by control byte 0x20 for an odd frame, and two zero bytes otherwise.
- R9: An accepted frame gives exactly one one-cycle pulse on both `q_push` and `rx_event`, with `q_page` equal to the page taken for it. The pulse comes after the last record write.
- R10: `busy` is 1 from the cycle after an accepted start byte until the frame is queued or released, and is 0 otherwise. A frame whose start byte arrives while `busy` is 1 is ignored entirely.
- R11: After reset, `busy`, `wr_en`, `alloc_take`, `rel_valid`, `q_push` and `rx_event` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_soft_rst | input | 1 | Soft reset held by software; blocks reception |
| cfg_strip_crc | input | 1 | Omit the CRC from the record |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Frame byte |
| alloc_avail | input | 1 | Allocator has a free page |
| alloc_page | input | PW | Page the allocator offers |
| alloc_take | output | 1 | Offered page is claimed (one-cycle pulse) |
| rel_valid | output | 1 | Page returned unused |
| rel_page | output | PW | Returned page |
| wr_en | output | 1 | Page memory byte write |
| wr_page | output | PW | Write page |
| wr_addr | output | AW | Write byte offset within the page |
| wr_data | output | 8 | Write data |
| q_push | output | 1 | Push into the receive queue |
| q_page | output | PW | Page pushed |
| rx_event | output | 1 | Receive event pulse |
| busy | output | 1 | A record is being built |

## Verification
A wrong length counter or wrong sequencer state shows up in the record itself: a shifted CRC, a wrong count word or a missing pad byte. It can be seen as soon as the queue pulse for that frame arrives, about twelve cycles after the end byte for long frames. A wrong running CRC register corrupts only the four CRC bytes of the frame in progress. A wrong accept decision shows up within one cycle of the start byte as a spurious or missing `alloc_take`. An error at the size boundary shows as a `rel_valid` pulse where a push was expected, or the reverse. The bench sweeps every frame length around the pad and page limits, with the CRC both kept and stripped, and rebuilds each record arithmetically.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_EVAL,
    S_PAD,
    S_CRC,
    S_TAIL,
    S_HEAD,
    S_FIN
  } rxf_state_e;

  // One byte of a reflected CRC-32 update, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);

  logic [31:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= CRC_INIT;
    end else if (start) begin
      acc_q <= crc32_step(CRC_INIT, din);
    end else if (en) begin
      acc_q <= crc32_step(acc_q, din);
    end
  end

  assign crc_o = ~acc_q;

endmodule

// File: rtl/rxf_sizer.sv
module rxf_sizer #(
  parameter int PAGE_BYTES = 2048,
  parameter int LONG_LIMIT = 1518,
  parameter int MIN_FRAME  = 64,
  parameter int LW         = 13
) (
  input  logic [LW-1:0] len,
  input  logic          strip,
  output logic [LW-1:0] rec_count,
  output logic [LW-1:0] body_end,
  output logic [15:0]   status,
  output logic          odd,
  output logic          short_frm,
  output logic          fits
);

  localparam logic [LW-1:0] MIN_L  = LW'(MIN_FRAME);
  localparam logic [LW-1:0] HDR_L  = LW'(4);
  localparam logic [LW-1:0] TRL_L  = LW'(2);
  localparam logic [LW-1:0] CRC_L  = LW'(4);
  localparam logic [LW-1:0] PAGE_L = LW'(PAGE_BYTES);
  localparam logic [LW-1:0] LONG_L = LW'(LONG_LIMIT);

  logic [LW-1:0] even_len;
  logic          too_long;

  always_comb begin
    short_frm = (len < MIN_L);
    even_len  = short_frm ? MIN_L : {len[LW-1:1], 1'b0};
    odd       = !short_frm && len[0];
    too_long  = (len > LONG_L);
    body_end  = HDR_L + even_len;
    rec_count = body_end + TRL_L + (strip ? '0 : CRC_L);
    fits      = (rec_count <= PAGE_L);
    status    = {3'b000, odd, too_long, 11'd0};
  end

endmodule

// File: rtl/rx_frame_formatter.sv
module rx_frame_formatter
  import rxf_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int NUM_PAGES  = 4,
  parameter int LONG_LIMIT = 1518,
  parameter int MIN_FRAME  = 64,
  localparam int AW = $clog2(PAGE_BYTES),
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rx_en,
  input  logic          cfg_soft_rst,
  input  logic          cfg_strip_crc,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_byte,
  input  logic          alloc_avail,
  input  logic [PW-1:0] alloc_page,
  output logic          alloc_take,
  output logic          rel_valid,
  output logic [PW-1:0] rel_page,
  output logic          wr_en,
  output logic [PW-1:0] wr_page,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          q_push,
  output logic [PW-1:0] q_page,
  output logic          rx_event,
  output logic          busy
);

  localparam int LW = AW + 2;
  localparam logic [LW-1:0] HDR_L    = LW'(4);
  localparam logic [LW-1:0] PAGE_L   = LW'(PAGE_BYTES);
  localparam logic [LW-1:0] STREAM_L = LW'(PAGE_BYTES - 4);
  localparam logic [LW-1:0] PAD_LAST = LW'(4 + MIN_FRAME - 1);
  localparam logic [7:0]    ODD_CTRL = 8'h20;

  rxf_state_e    state;
  logic [PW-1:0] page_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] ptr_q;
  logic [1:0]    sub_q;
  logic [7:0]    last_q;
  logic          strip_q;

  logic          accept;
  logic          crc_start;
  logic          crc_en;
  logic [31:0]   crc_val;
  logic [LW-1:0] rec_count;
  logic [LW-1:0] body_end;
  logic [15:0]   status;
  logic [15:0]   count16;
  logic          odd;
  logic          short_frm;
  logic          fits;

  assign accept    = (state == S_IDLE) && in_valid && in_sof &&
                     cfg_rx_en && !cfg_soft_rst && alloc_avail;
  assign crc_start = accept;
  assign crc_en    = (state == S_RECV) && in_valid;
  assign busy      = (state != S_IDLE);
  assign count16   = 16'(rec_count);

  rxf_crc32 u_crc (
    .clk   (clk),
    .rst   (rst),
    .start (crc_start),
    .en    (crc_en),
    .din   (in_byte),
    .crc_o (crc_val)
  );

  rxf_sizer #(
    .PAGE_BYTES (PAGE_BYTES),
    .LONG_LIMIT (LONG_LIMIT),
    .MIN_FRAME  (MIN_FRAME),
    .LW         (LW)
  ) u_sizer (
    .len       (len_q),
    .strip     (strip_q),
    .rec_count (rec_count),
    .body_end  (body_end),
    .status    (status),
    .odd       (odd),
    .short_frm (short_frm),
    .fits      (fits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      page_q     <= '0;
      len_q      <= '0;
      ptr_q      <= '0;
      sub_q      <= '0;
      last_q     <= '0;
      strip_q    <= 1'b0;
      alloc_take <= 1'b0;
      rel_valid  <= 1'b0;
      rel_page   <= '0;
      wr_en      <= 1'b0;
      wr_page    <= '0;
      wr_addr    <= '0;
      wr_data    <= '0;
      q_push     <= 1'b0;
      q_page     <= '0;
      rx_event   <= 1'b0;
    end else begin
      alloc_take <= 1'b0;
      rel_valid  <= 1'b0;
      wr_en      <= 1'b0;
      q_push     <= 1'b0;
      rx_event   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            page_q     <= alloc_page;
            alloc_take <= 1'b1;
            strip_q    <= cfg_strip_crc;
            len_q      <= LW'(1);
            last_q     <= in_byte;
            wr_en      <= 1'b1;
            wr_page    <= alloc_page;
            wr_addr    <= AW'(HDR_L);
            wr_data    <= in_byte;
            state      <= in_eof ? S_EVAL : S_RECV;
          end
        end
        S_RECV: begin
          if (in_valid) begin
            last_q <= in_byte;
            if (len_q < STREAM_L) begin
              wr_en   <= 1'b1;
              wr_page <= page_q;
              wr_addr <= AW'(HDR_L + len_q);
              wr_data <= in_byte;
            end
            if (len_q != PAGE_L) begin
              len_q <= len_q + LW'(1);
            end
            if (in_eof) begin
              state <= S_EVAL;
            end
          end
        end
        S_EVAL: begin
          sub_q <= '0;
          if (!fits) begin
            rel_valid <= 1'b1;
            rel_page  <= page_q;
            state     <= S_IDLE;
          end else if (short_frm) begin
            ptr_q <= HDR_L + len_q;
            state <= S_PAD;
          end else begin
            ptr_q <= body_end;
            state <= strip_q ? S_TAIL : S_CRC;
          end
        end
        S_PAD: begin
          wr_en   <= 1'b1;
          wr_page <= page_q;
          wr_addr <= AW'(ptr_q);
          wr_data <= 8'h00;
          ptr_q   <= ptr_q + LW'(1);
          if (ptr_q == PAD_LAST) begin
            state <= strip_q ? S_TAIL : S_CRC;
          end
        end
        S_CRC: begin
          wr_en   <= 1'b1;
          wr_page <= page_q;
          wr_addr <= AW'(ptr_q);
          wr_data <= crc_val[8*sub_q +: 8];
          ptr_q   <= ptr_q + LW'(1);
          sub_q   <= sub_q + 2'd1;
          if (sub_q == 2'd3) begin
            state <= S_TAIL;
          end
        end
        S_TAIL: begin
          wr_en   <= 1'b1;
          wr_page <= page_q;
          wr_addr <= AW'(ptr_q);
          ptr_q   <= ptr_q + LW'(1);
          if (sub_q == 2'd0) begin
            wr_data <= odd ? last_q : 8'h00;
            sub_q   <= 2'd1;
          end else begin
            wr_data <= odd ? ODD_CTRL : 8'h00;
            sub_q   <= 2'd0;
            state   <= S_HEAD;
          end
        end
        S_HEAD: begin
          wr_en   <= 1'b1;
          wr_page <= page_q;
          wr_addr <= AW'(sub_q);
          unique case (sub_q)
            2'd0:    wr_data <= status[7:0];
            2'd1:    wr_data <= status[15:8];
            2'd2:    wr_data <= count16[7:0];
            default: wr_data <= count16[15:8];
          endcase
          sub_q <= sub_q + 2'd1;
          if (sub_q == 2'd3) begin
            state <= S_FIN;
          end
        end
        S_FIN: begin
          q_push   <= 1'b1;
          q_page   <= page_q;
          rx_event <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_rx_en,
  input logic          cfg_soft_rst,
  input logic          in_valid,
  input logic          in_sof,
  input logic          alloc_avail,
  input logic          alloc_take,
  input logic          rel_valid,
  input logic          wr_en,
  input logic          q_push,
  input logic          busy
);

  // R1
  a_r1_refuse_disabled: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && in_sof && (!cfg_rx_en || cfg_soft_rst)) |=> !alloc_take);

  // R2
  a_r2_refuse_no_page: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && in_sof && !alloc_avail) |=> !alloc_take);

  // R3
  a_r3_release_or_push: assert property (@(posedge clk) disable iff (rst)
    !(rel_valid && q_push));

  // R9
  a_r9_push_after_writes: assert property (@(posedge clk) disable iff (rst)
    q_push |-> $past(wr_en));

  // R9
  a_r9_single_push: assert property (@(posedge clk) disable iff (rst)
    q_push |=> !q_push);

  // R10
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_en);

  // R10
  a_r10_take_while_busy: assert property (@(posedge clk) disable iff (rst)
    alloc_take |-> busy);

endmodule

bind rx_frame_formatter rxf_checks #(.PW(PW)) u_rxf_checks (
  .clk          (clk),
  .rst          (rst),
  .cfg_rx_en    (cfg_rx_en),
  .cfg_soft_rst (cfg_soft_rst),
  .in_valid     (in_valid),
  .in_sof       (in_sof),
  .alloc_avail  (alloc_avail),
  .alloc_take   (alloc_take),
  .rel_valid    (rel_valid),
  .wr_en        (wr_en),
  .q_push       (q_push),
  .busy         (busy)
);

// File: tb/rx_frame_formatter_tb_top.sv
module rx_frame_formatter_tb_top;

  localparam int PB = 128;
  localparam int NP = 4;
  localparam int LL = 100;
  localparam int MF = 64;
  localparam int AW = $clog2(PB);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_rx_en = 1'b1, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]    in_byte = '0;
  logic          alloc_avail;
  logic [PW-1:0] alloc_page;
  logic          alloc_take, rel_valid, wr_en, q_push, rx_event, busy;
  logic [PW-1:0] rel_page, wr_page, q_page;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  rx_frame_formatter #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .LONG_LIMIT(LL), .MIN_FRAME(MF)) dut_i (
    .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_soft_rst(cfg_soft_rst),
    .cfg_strip_crc(cfg_strip_crc), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_byte(in_byte), .alloc_avail(alloc_avail), .alloc_page(alloc_page),
    .alloc_take(alloc_take), .rel_valid(rel_valid), .rel_page(rel_page),
    .wr_en(wr_en), .wr_page(wr_page), .wr_addr(wr_addr), .wr_data(wr_data),
    .q_push(q_push), .q_page(q_page), .rx_event(rx_event), .busy(busy));

  // Bench-side pool, memory and event log; owned by the monitor only.
  logic [7:0]    mem [NP][PB];
  logic [NP-1:0] fm = '1;
  logic          cmd_pool = 1'b0;
  int push_cnt = 0, rel_cnt = 0, take_cnt = 0, wr_cnt = 0, evt_bad = 0;
  int last_push = 0, last_rel = 0, last_take = 0;
  int checks = 0, fails = 0;

  always_comb begin
    alloc_avail = |fm;
    alloc_page  = '0;
    for (int i = NP - 1; i >= 0; i--) if (fm[i]) alloc_page = PW'(i);
  end

  always @(negedge clk) begin
    if (cmd_pool) begin
      fm = '1;
      for (int p = 0; p < NP; p++) for (int a = 0; a < PB; a++) mem[p][a] = 8'hAA;
    end else if (!rst) begin
      if (wr_en) begin mem[wr_page][wr_addr] = wr_data; wr_cnt++; end
      if (alloc_take) begin fm[alloc_page] = 1'b0; take_cnt++; last_take = int'(alloc_page); end
      if (rel_valid) begin fm[rel_page] = 1'b1; rel_cnt++; last_rel = int'(rel_page); end
      if (q_push) begin push_cnt++; last_push = int'(q_page); end
      if (q_push != rx_event) evt_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int seed, input int i);
    return 8'((seed * 7 + i * 13 + 5) & 255);
  endfunction

  function automatic logic [31:0] crc_ref(input int seed, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      logic [7:0] d = dat(seed, i);
      for (int j = 0; j < 8; j++) begin
        logic b = c[0] ^ d[j];
        c = c >> 1;
        if (b) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic pool_reset();
    cmd_pool = 1'b1;
    @(negedge clk); #1;
    cmd_pool = 1'b0;
  endtask

  task automatic drive(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_byte = dat(seed, i);
      @(negedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    do begin @(negedge clk); #1; t++; end while (busy && t < 600);
    chk(t < 600, "R10 busy clears", t, 600);
  endtask

  task automatic verify(input int pg, input int len, input bit strip, input int seed);
    int  ev = (len < MF) ? MF : (len & ~1);
    bit  od = (len >= MF) && (len % 2 == 1);
    int  cnt = 6 + ev + (strip ? 0 : 4);
    int  st = (od ? 'h1000 : 0) | ((len > LL) ? 'h0800 : 0);
    int  bad, first;
    logic [31:0] cv = crc_ref(seed, len);
    int  te = 4 + ev + (strip ? 0 : 4);
    chk({mem[pg][3], mem[pg][2]} == 16'(cnt), "R5 count word", int'({mem[pg][3], mem[pg][2]}), cnt);
    chk({mem[pg][1], mem[pg][0]} == 16'(st), "R6 status word", int'({mem[pg][1], mem[pg][0]}), st);
    bad = 0; first = 0;
    for (int i = 0; i < ev; i++) begin
      logic [7:0] e = (i < len) ? dat(seed, i) : 8'h00;
      if (mem[pg][4 + i] != e) begin if (bad == 0) first = i; bad++; end
    end
    chk(bad == 0, "R4 payload and padding", first, bad);
    if (!strip) begin
      logic [31:0] got = {mem[pg][4 + ev + 3], mem[pg][4 + ev + 2], mem[pg][4 + ev + 1], mem[pg][4 + ev]};
      chk(got == cv, "R7 crc bytes", int'(got), int'(cv));
    end
    chk(mem[pg][te] == (od ? dat(seed, len - 1) : 8'h00), "R8 trailing byte",
        int'(mem[pg][te]), int'(od ? dat(seed, len - 1) : 8'h00));
    chk(mem[pg][te + 1] == (od ? 8'h20 : 8'h00), "R8 control byte",
        int'(mem[pg][te + 1]), od ? 32 : 0);
  endtask

  task automatic one_frame(input int len, input bit strip, input int seed);
    int p0, r0, t0, ev, cnt;
    ev = (len < MF) ? MF : (len & ~1);
    cnt = 6 + ev + (strip ? 0 : 4);
    pool_reset();
    cfg_strip_crc = strip;
    p0 = push_cnt; r0 = rel_cnt; t0 = take_cnt;
    drive(len, seed);
    wait_idle();
    chk(take_cnt == t0 + 1, "R9 page taken", take_cnt - t0, 1);
    if (cnt <= PB) begin
      chk(push_cnt == p0 + 1 && rel_cnt == r0, "R9 one push", push_cnt - p0, 1);
      chk(last_push == last_take, "R9 pushed page", last_push, last_take);
      verify(last_push, len, strip, seed);
    end else begin
      chk(rel_cnt == r0 + 1 && push_cnt == p0, "R3 oversize released", rel_cnt - r0, 1);
      chk(last_rel == last_take, "R3 released page", last_rel, last_take);
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p0, t0, w0;
    pool_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !wr_en && !alloc_take && !rel_valid && !q_push && !rx_event,
        "R11 reset outputs", int'({busy, wr_en, alloc_take, rel_valid, q_push, rx_event}), 0);
    rst = 1'b0;
    @(negedge clk); #1;

    // R1: disabled and soft reset both refuse
    for (int m = 0; m < 2; m++) begin
      pool_reset();
      cfg_rx_en = (m == 1); cfg_soft_rst = (m == 1);
      p0 = push_cnt; t0 = take_cnt; w0 = wr_cnt;
      drive(70, 3);
      repeat (20) @(negedge clk);
      #1;
      chk(take_cnt == t0 && push_cnt == p0 && wr_cnt == w0, "R1 refused frame",
          take_cnt - t0 + wr_cnt - w0, 0);
    end
    cfg_rx_en = 1'b1; cfg_soft_rst = 1'b0;

    // Length sweep across pad, odd, too-long and page limits, CRC kept and stripped
    for (int s = 0; s < 2; s++)
      for (int len = 1; len <= PB + 4; len++)
        one_frame(len, s[0], len + 31 * s);

    // R2: pool exhaustion; pages held, fifth frame refused
    pool_reset();
    cfg_strip_crc = 1'b0;
    for (int k = 0; k < NP; k++) begin
      drive(64, 50 + k);
      wait_idle();
      chk(last_push == k, "R2 lowest free page pushed", last_push, k);
    end
    p0 = push_cnt; t0 = take_cnt; w0 = wr_cnt;
    drive(64, 60);
    repeat (20) @(negedge clk);
    #1;
    chk(take_cnt == t0 && push_cnt == p0 && wr_cnt == w0, "R2 no page refused",
        push_cnt - p0 + wr_cnt - w0, 0);

    // R10: a second frame starting while busy is dropped
    pool_reset();
    p0 = push_cnt; t0 = take_cnt;
    drive(70, 9);
    chk(busy == 1'b1, "R10 busy after frame end", int'(busy), 1);
    drive(10, 77);
    wait_idle();
    repeat (5) @(negedge clk);
    #1;
    chk(push_cnt == p0 + 1 && take_cnt == t0 + 1, "R10 overlapping frame dropped", push_cnt - p0, 1);
    verify(last_push, 70, 1'b0, 9);

    chk(evt_bad == 0, "R9 event matches push", evt_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule